// File: doc/BRIEF.md
# Cache Performance Counter Bank

This block is the counting core of a cluster-level cache performance monitor. It holds a configurable number of 32-bit event counters and one 64-bit cycle counter. Each event counter advances on a single-cycle increment strobe that logic outside the block supplies. The cycle counter advances on every clock while it is enabled. When a counter passes its full-scale value it wraps to zero and raises a sticky overflow flag. An interrupt line reports any flag whose interrupt is enabled.

Software reaches every register through a two-register window. A select register holds a 16-bit internal address, and a data port writes to or reads from the register that the select value names. The enable, interrupt-enable and overflow state are three 32-bit masks. Each mask has a set address and a clear address, and both take write-one semantics. Event counter n is bit n of each mask, and the cycle counter is always bit 31.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset all counters, all three masks, the global enable and the per-counter configuration registers are zero, and `irq` is low. The control register (0x400) reads back the event-counter count in bits [15:11] and the global enable in bit 0.
- R2: A data write goes to the register named by the select value last written, and the read data reflects that register at once. The fixed addresses are: 0x400 control, 0x403/0x404 enable clear/set, 0x405/0x406 interrupt-enable clear/set, 0x407/0x408 overflow clear/set, 0x409 cycle control, 0x40A cycle value. Counter n is at 0x420+0x10*n, with offset 0 for control, 1 for value, 3 for filter and 4 for type.
- R3: Event counter n gains one on each clock where its strobe is high, control bit 0 is set and enable-mask bit n is set. Otherwise it holds.
- R4: The cycle counter is 64 bits wide. It gains one on every clock edge at which control bit 0 and enable-mask bit 31 were both set.
- R5: An event counter that increments from 0xFFFFFFFF becomes 0 and sets overflow bit n. The cycle counter wrapping from all ones sets overflow bit 31.
- R6: Reading 0x408 or 0x407 returns the overflow flags. Writing ones to 0x407 clears exactly those flags, and writing ones to 0x408 sets them.
- R7: `irq` is high exactly while some overflow bit and the same interrupt-enable bit are both set. 0x406 sets interrupt-enable bits and 0x405 clears them.
- R8: A control write with bit 1 set zeroes every event counter, and one with bit 2 set zeroes the cycle counter, so 0x6 zeroes all. Masks are unaffected, and bit 0 of the same write sets the global enable.
- R9: Software can write any value into a counter. A value write wins over an increment in the same cycle.
- R10: An unmapped address reads zero and ignores writes. Mask bits that belong to no counter read zero and cannot be set.
- R11: Each counter's control, filter and type registers and the cycle control register store and return 32-bit values. They have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | 16 | New internal address |
| dat_we | input | 1 | Write the selected register |
| dat_wdata | input | 64 | Write data (32-bit registers use bits [31:0]) |
| dat_rdata | output | 64 | Contents of the selected register, zero-extended |
| ev_strobe | input | NUM_EV | Per-counter increment strobes |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs with four event counters. It sweeps all sixteen enable patterns against varied strobe sequences with the global enable on and then off. A design that ignored either enable would count strobes the bench expects to be dropped. Counters are preloaded just below full scale to exercise the wrap. A design that saturated, missed the flag or put the cycle flag at bit NUM_EV would read back the wrong value or mask. The bench also checks that clearing one overflow bit leaves the others set, that a value write wins over a same-cycle strobe, and that writes to addresses just beside mapped ones change nothing.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 64;
    localparam int MASK_W   = 32;
    localparam int CYC_BIT  = 31;
    localparam int NEV_LSB  = 11;

    localparam logic [15:0] A_CTRL     = 16'h0400;
    localparam logic [15:0] A_EN_CLR   = 16'h0403;
    localparam logic [15:0] A_EN_SET   = 16'h0404;
    localparam logic [15:0] A_IE_CLR   = 16'h0405;
    localparam logic [15:0] A_IE_SET   = 16'h0406;
    localparam logic [15:0] A_OV_CLR   = 16'h0407;
    localparam logic [15:0] A_OV_SET   = 16'h0408;
    localparam logic [15:0] A_CYC_CTL  = 16'h0409;
    localparam logic [15:0] A_CYC_VAL  = 16'h040A;
    localparam logic [15:0] A_BANK     = 16'h0420;

    typedef enum logic [3:0] {
        RK_NONE, RK_CTRL, RK_EN_CLR, RK_EN_SET, RK_IE_CLR, RK_IE_SET,
        RK_OV_CLR, RK_OV_SET, RK_CYC_CTL, RK_CYC_VAL,
        RK_EV_CTL, RK_EV_VAL, RK_EV_FLT, RK_EV_TYP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [4:0] idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [15:0] a, input int nev);
        reg_dec_t   d;
        logic [15:0] off;
        d.kind = RK_NONE;
        d.idx  = '0;
        off    = a - A_BANK;
        case (a)
            A_CTRL:    d.kind = RK_CTRL;
            A_EN_CLR:  d.kind = RK_EN_CLR;
            A_EN_SET:  d.kind = RK_EN_SET;
            A_IE_CLR:  d.kind = RK_IE_CLR;
            A_IE_SET:  d.kind = RK_IE_SET;
            A_OV_CLR:  d.kind = RK_OV_CLR;
            A_OV_SET:  d.kind = RK_OV_SET;
            A_CYC_CTL: d.kind = RK_CYC_CTL;
            A_CYC_VAL: d.kind = RK_CYC_VAL;
            default: begin
                if (a >= A_BANK && int'(off[15:4]) < nev) begin
                    d.idx = off[8:4];
                    case (off[3:0])
                        4'h0:    d.kind = RK_EV_CTL;
                        4'h1:    d.kind = RK_EV_VAL;
                        4'h3:    d.kind = RK_EV_FLT;
                        4'h4:    d.kind = RK_EV_TYP;
                        default: d.kind = RK_NONE;
                    endcase
                end
            end
        endcase
        return d;
    endfunction

    function automatic logic [31:0] present_mask(input int nev);
        return ((32'd1 << nev) - 32'd1) | (32'd1 << CYC_BIT);
    endfunction

endpackage

// File: rtl/pmu_ctr.sv
module pmu_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    assign wrap = inc && !clr && !ld && (&cnt);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (ld)     cnt <= ld_val;
        else if (inc)    cnt <= cnt + W'(1);
    end

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> (cnt == $past(ld_val)));
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld && !clr) |=> $stable(cnt));
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/pmu_maskreg.sv
module pmu_maskreg #(
    parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_set,
    output logic [31:0] q
);

    logic [31:0] nxt;

    always_comb begin
        nxt = q;
        if (set_we) nxt = nxt | wdata;
        if (clr_we) nxt = nxt & ~wdata;
        nxt = (nxt | hw_set) & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assert_clear_exact_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we && hw_set == '0)
        |=> ((q & $past(wdata)) == '0) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
    assert_absent_bits_R10: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & ~VALID) == '0));

endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
    import pmu_pkg::*;
#(
    parameter int NUM_EV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic [15:0]       sel_wdata,
    input  logic              dat_we,
    input  logic [63:0]       dat_wdata,
    output logic [63:0]       dat_rdata,
    input  logic [NUM_EV-1:0] ev_strobe,
    output logic              irq
);

    localparam logic [31:0] VALID     = present_mask(NUM_EV);
    localparam logic [4:0]  NEV_FIELD = 5'(NUM_EV);

    logic [15:0] sel_q;
    logic        gen_q;
    logic [31:0] cyc_ctl_q;
    reg_dec_t    dec;
    logic [31:0] en_q, ie_q, ov_q, ov_hw;
    logic [63:0] cyc_cnt;
    logic        cyc_wrap;
    logic        ctrl_wr, clr_ev, clr_cyc;
    logic [63:0] bank_rd [NUM_EV];

    assign dec     = decode_addr(sel_q, NUM_EV);
    assign ctrl_wr = dat_we && dec.kind == RK_CTRL;
    assign clr_ev  = ctrl_wr && dat_wdata[1];
    assign clr_cyc = ctrl_wr && dat_wdata[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            gen_q     <= 1'b0;
            cyc_ctl_q <= '0;
        end else begin
            if (sel_we) sel_q <= sel_wdata;
            if (ctrl_wr) gen_q <= dat_wdata[0];
            if (dat_we && dec.kind == RK_CYC_CTL) cyc_ctl_q <= dat_wdata[31:0];
        end
    end

    pmu_maskreg #(.VALID(VALID)) u_en (
        .clk(clk), .rst(rst),
        .set_we(dat_we && dec.kind == RK_EN_SET),
        .clr_we(dat_we && dec.kind == RK_EN_CLR),
        .wdata(dat_wdata[31:0]), .hw_set(32'd0), .q(en_q));

    pmu_maskreg #(.VALID(VALID)) u_ie (
        .clk(clk), .rst(rst),
        .set_we(dat_we && dec.kind == RK_IE_SET),
        .clr_we(dat_we && dec.kind == RK_IE_CLR),
        .wdata(dat_wdata[31:0]), .hw_set(32'd0), .q(ie_q));

    pmu_maskreg #(.VALID(VALID)) u_ov (
        .clk(clk), .rst(rst),
        .set_we(dat_we && dec.kind == RK_OV_SET),
        .clr_we(dat_we && dec.kind == RK_OV_CLR),
        .wdata(dat_wdata[31:0]), .hw_set(ov_hw), .q(ov_q));

    pmu_ctr #(.W(64)) u_cyc (
        .clk(clk), .rst(rst), .clr(clr_cyc),
        .ld(dat_we && dec.kind == RK_CYC_VAL), .ld_val(dat_wdata),
        .inc(gen_q && en_q[CYC_BIT]), .cnt(cyc_cnt), .wrap(cyc_wrap));

    assign ov_hw[CYC_BIT] = cyc_wrap;

    for (genvar j = NUM_EV; j < CYC_BIT; j++) begin : g_gap
        assign ov_hw[j] = 1'b0;
    end

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        logic        hit;
        logic [31:0] cnt, ctl, flt, typ;

        assign hit = (dec.idx == 5'(i));

        pmu_ctr #(.W(32)) u_ctr (
            .clk(clk), .rst(rst), .clr(clr_ev),
            .ld(dat_we && hit && dec.kind == RK_EV_VAL),
            .ld_val(dat_wdata[31:0]),
            .inc(gen_q && en_q[i] && ev_strobe[i]),
            .cnt(cnt), .wrap(ov_hw[i]));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl <= '0;
                flt <= '0;
                typ <= '0;
            end else if (dat_we && hit) begin
                if (dec.kind == RK_EV_CTL) ctl <= dat_wdata[31:0];
                if (dec.kind == RK_EV_FLT) flt <= dat_wdata[31:0];
                if (dec.kind == RK_EV_TYP) typ <= dat_wdata[31:0];
            end
        end

        always_comb begin
            bank_rd[i] = '0;
            if (hit) begin
                case (dec.kind)
                    RK_EV_CTL: bank_rd[i] = {32'd0, ctl};
                    RK_EV_VAL: bank_rd[i] = {32'd0, cnt};
                    RK_EV_FLT: bank_rd[i] = {32'd0, flt};
                    RK_EV_TYP: bank_rd[i] = {32'd0, typ};
                    default:   bank_rd[i] = '0;
                endcase
            end
        end
    end

    always_comb begin
        dat_rdata = '0;
        case (dec.kind)
            RK_CTRL: begin
                dat_rdata[NEV_LSB +: 5] = NEV_FIELD;
                dat_rdata[0]            = gen_q;
            end
            RK_EN_CLR, RK_EN_SET: dat_rdata = {32'd0, en_q};
            RK_IE_CLR, RK_IE_SET: dat_rdata = {32'd0, ie_q};
            RK_OV_CLR, RK_OV_SET: dat_rdata = {32'd0, ov_q};
            RK_CYC_CTL:           dat_rdata = {32'd0, cyc_ctl_q};
            RK_CYC_VAL:           dat_rdata = cyc_cnt;
            default: begin
                for (int i = 0; i < NUM_EV; i++) dat_rdata = dat_rdata | bank_rd[i];
            end
        endcase
    end

    assign irq = |(ov_q & ie_q);

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (dat_we && dec.kind == RK_NONE) |=> ($stable(en_q) && $stable(ie_q) && $stable(gen_q)));
    assert_cyc_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        (!gen_q && !dat_we) |=> $stable(cyc_cnt));
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        (ie_q == '0) |-> !irq);

endmodule

// File: tb/test_pmu_counter_bank.sv
module test_pmu_counter_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NEV = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sel_we = 1'b0;
    logic [15:0]    sel_wdata = '0;
    logic           dat_we = 1'b0;
    logic [63:0]    dat_wdata = '0;
    logic [63:0]    dat_rdata;
    logic [NEV-1:0] ev_strobe = '0;
    logic           irq;

    int n_run = 0;
    int n_fail = 0;
    longint tick = 0;
    logic [31:0] exp_cnt [NEV];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_counter_bank #(.NUM_EV(NEV)) i_pmu_counter_bank (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .ev_strobe(ev_strobe), .irq(irq));

    always @(posedge clk) begin
        tick <= tick + 1;
        if (tick > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung act=%0d exp=<100000", tick);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wsel(input logic [15:0] a);
        sel_we = 1'b1; sel_wdata = a;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic wdat(input logic [15:0] a, input logic [63:0] d);
        wsel(a);
        dat_we = 1'b1; dat_wdata = d;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] v);
        wsel(a);
        v = dat_rdata;
    endtask

    function automatic logic [15:0] ev_addr(input int i, input int sub);
        return 16'(16'h420 + 16'h10 * i + sub);
    endfunction

    initial begin
        logic [63:0] v;
        longint s0, s1;
        logic [63:0] cstart;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(16'h400, v); chk("R1 ctrl after reset", v, 64'(NEV << 11));
        rd(16'h408, v); chk("R1 overflow after reset", v, 0);
        rd(16'h404, v); chk("R1 enable after reset", v, 0);
        rd(16'h40A, v); chk("R1 cycle after reset", v, 0);
        for (int i = 0; i < NEV; i++) begin
            rd(ev_addr(i, 1), v); chk("R1 counter after reset", v, 0);
            rd(ev_addr(i, 4), v); chk("R1 type after reset", v, 0);
        end
        chk("R1 irq after reset", 64'(irq), 0);

        // R11 configuration storage, R2 addressing
        for (int i = 0; i < NEV; i++) begin
            wdat(ev_addr(i, 0), 64'(32'hC000_0000 + i));
            wdat(ev_addr(i, 3), 64'(32'h0F00_0000 + 16 * i));
            wdat(ev_addr(i, 4), 64'(32'h0000_0A00 + 3 * i));
        end
        wdat(16'h409, 64'h5A5A_1234);
        for (int i = 0; i < NEV; i++) begin
            rd(ev_addr(i, 0), v); chk("R11 R2 counter control", v, 64'(32'hC000_0000 + i));
            rd(ev_addr(i, 3), v); chk("R11 R2 filter", v, 64'(32'h0F00_0000 + 16 * i));
            rd(ev_addr(i, 4), v); chk("R11 R2 type", v, 64'(32'h0000_0A00 + 3 * i));
            rd(ev_addr(i, 1), v); chk("R11 value untouched", v, 0);
        end
        rd(16'h409, v); chk("R11 cycle control", v, 64'h5A5A_1234);

        // R10 unmapped addresses and absent mask bits
        begin
            logic [15:0] holes [7] = '{16'h401, 16'h402, 16'h40B, 16'h422, 16'h425,
                                       16'(16'h420 + 16'h10 * NEV), 16'h3FF};
            foreach (holes[k]) begin
                wdat(holes[k], 64'hFFFF_FFFF_DEAD_BEEF);
                rd(holes[k], v); chk("R10 unmapped reads zero", v, 0);
            end
        end
        rd(16'h400, v); chk("R10 ctrl unchanged", v, 64'(NEV << 11));
        rd(16'h404, v); chk("R10 enable unchanged", v, 0);
        rd(16'h406, v); chk("R10 int-enable unchanged", v, 0);
        wdat(16'h404, 64'hFFFF_FFFF);
        rd(16'h403, v); chk("R10 absent enable bits", v, 64'h8000_000F);
        wdat(16'h403, 64'hFFFF_FFFF);
        rd(16'h404, v); chk("R10 enable cleared", v, 0);

        // R3 sweep over every enable pattern
        for (int pat = 0; pat < 16; pat++) begin
            wdat(16'h400, 64'h3);
            wdat(16'h403, 64'hFFFF_FFFF);
            wdat(16'h404, 64'(pat));
            for (int i = 0; i < NEV; i++) exp_cnt[i] = 0;
            for (int c = 0; c < 12; c++) begin
                logic [3:0] s;
                s = 4'(c * 5 + pat * 3 + c / 3);
                ev_strobe = s;
                for (int i = 0; i < NEV; i++)
                    if (s[i] && pat[i]) exp_cnt[i] = exp_cnt[i] + 1;
                @(negedge clk);
            end
            ev_strobe = '0;
            wdat(16'h400, 64'h0);
            ev_strobe = '1;
            repeat (4) @(negedge clk);
            ev_strobe = '0;
            for (int i = 0; i < NEV; i++) begin
                rd(ev_addr(i, 1), v); chk("R3 enable pattern count", v, 64'(exp_cnt[i]));
            end
        end
        rd(16'h408, v); chk("R3 no stray overflow", v, 0);

        // R4 cycle counter
        wdat(16'h400, 64'h4);
        wdat(16'h403, 64'hFFFF_FFFF);
        wdat(16'h404, 64'h8000_0000);
        wdat(16'h400, 64'h1); s0 = tick;
        repeat (37) @(negedge clk);
        wdat(16'h400, 64'h0); s1 = tick;
        rd(16'h40A, v); chk("R4 cycle count", v, 64'(s1 - s0));
        repeat (5) @(negedge clk);
        rd(16'h40A, v); chk("R4 cycle frozen when disabled", v, 64'(s1 - s0));

        // R5 event wrap, R6 flag handling, R7 interrupt
        wdat(16'h407, 64'hFFFF_FFFF);
        wdat(16'h404, 64'hF);
        wdat(16'h403, 64'h8000_0000);
        wdat(ev_addr(2, 1), 64'hFFFF_FFFE);
        wdat(16'h400, 64'h1);
        ev_strobe = 4'b0100;
        @(negedge clk);
        @(negedge clk);
        ev_strobe = '0;
        wdat(16'h400, 64'h0);
        rd(ev_addr(2, 1), v); chk("R5 event wrap to zero", v, 0);
        rd(16'h408, v); chk("R5 overflow bit n", v, 64'h4);
        chk("R7 irq low without enable", 64'(irq), 0);
        wdat(16'h406, 64'h4);
        chk("R7 irq high with enable", 64'(irq), 1);
        wdat(16'h405, 64'h4);
        chk("R7 irq low after disable", 64'(irq), 0);
        wdat(16'h406, 64'h4);
        wdat(16'h407, 64'h1);
        rd(16'h407, v); chk("R6 clear leaves other flags", v, 64'h4);
        chk("R7 irq still high", 64'(irq), 1);
        wdat(16'h407, 64'h4);
        rd(16'h408, v); chk("R6 clear exact flag", v, 0);
        chk("R7 irq low after flag clear", 64'(irq), 0);
        wdat(16'h408, 64'h8);
        rd(16'h408, v); chk("R6 set register sets flag", v, 64'h8);
        wdat(16'h407, 64'hFFFF_FFFF);

        // R5 cycle wrap
        cstart = 64'hFFFF_FFFF_FFFF_FFFC;
        wdat(16'h40A, cstart);
        wdat(16'h404, 64'h8000_0000);
        wdat(16'h400, 64'h1); s0 = tick;
        repeat (10) @(negedge clk);
        wdat(16'h400, 64'h0); s1 = tick;
        rd(16'h40A, v); chk("R5 cycle wraps", v, cstart + 64'(s1 - s0));
        rd(16'h408, v); chk("R5 cycle overflow bit 31", v, 64'h8000_0000);
        wdat(16'h406, 64'h8000_0000);
        chk("R7 irq from cycle flag", 64'(irq), 1);
        wdat(16'h407, 64'h8000_0000);
        wdat(16'h405, 64'hFFFF_FFFF);

        // R9 load beats increment
        wdat(16'h400, 64'h1);
        wsel(ev_addr(0, 1));
        dat_we = 1'b1; dat_wdata = 64'h1234; ev_strobe = 4'b0001;
        @(negedge clk);
        dat_we = 1'b0; ev_strobe = '0;
        rd(ev_addr(0, 1), v); chk("R9 load wins over strobe", v, 64'h1234);
        wdat(16'h400, 64'h0);
        wdat(ev_addr(1, 1), 64'h8000_0000);
        rd(ev_addr(1, 1), v); chk("R9 direct value write", v, 64'h8000_0000);

        // R8 reset-all control write
        wdat(16'h400, 64'h6);
        for (int i = 0; i < NEV; i++) begin
            rd(ev_addr(i, 1), v); chk("R8 event counter zeroed", v, 0);
        end
        rd(16'h40A, v); chk("R8 cycle zeroed", v, 0);
        rd(16'h404, v); chk("R8 enables kept", v, 64'h8000_000F);
        rd(16'h400, v); chk("R8 global enable follows bit 0", v, 64'(NEV << 11));

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule